// File: doc/BRIEF.md
# Virtqueue Used-Ring Completion Writer

This engine finishes one device request on a split virtqueue. It takes the head descriptor index of the request, the index where the device-writable part of the chain begins, and the total reply length. It then walks that writable chain in guest memory. The reply bytes arrive on a valid/ready byte stream, and the engine scatters them into the described buffers through a byte write port. When all bytes are placed, it appends a used-ring element, bumps the 16-bit used producer index and pulses a completion event. The event is meant to set bit 0 of the interrupt status held elsewhere.

The engine reads 32-bit words from memory with a fixed one-cycle latency. Before it writes anything, it walks the chain once to total the writable capacity. If the reply does not fit, or the chain has no writable part, the completion is dropped and nothing is written. In that case no reply byte is taken from the stream. The queue size is a power of two, given by its base-2 logarithm. The table base must be 4096-byte aligned, and the configuration must stay stable while the engine is busy.

Top module: `vq_used_writer`

## Requirements
- R1: The used ring base is (table base + 16×N + 4 + 2×N) rounded up to a multiple of 4096, where N = 2^cfg_qsize_lg.
- R2: Descriptor i starts at table base + 16×i. Its buffer address is the 32-bit word at offset 0, its length is the word at offset 8, its flags are the 16 bits at offset 12 and its next index is the 16 bits at offset 14. Flag bit 1 marks the buffer as writable and flag bit 0 means a next descriptor follows. All fields are little-endian.
- R3: Reply bytes are written in stream order. Each buffer is filled from its start address upward for at most its length, and then the next descriptor of the chain is used.
- R4: The used element is written at used base + 4 + 8×(old index AND (N−1)). It holds the request head index as a 32-bit little-endian word, followed by the reply length as a 32-bit little-endian word.
- R5: The 16-bit used index at used base + 2 is read, and (old + 1) mod 65536 is written back. These two bytes are the last writes of a completion, after the element.
- R6: A non-writable descriptor reached after at least one writable one ends the chain. Only writable buffers count towards the capacity.
- R7: If the chain-start descriptor is not writable, the completion is dropped: no memory write, no event, and no reply byte is consumed.
- R8: If the reply length exceeds the total capacity of the writable chain, the completion is dropped: no memory write, no event, and no reply byte is consumed.
- R9: busy is high from the cycle after a request is accepted until the cycle after the completion event or the drop. Requests presented while busy are ignored. irq_event is a single-cycle pulse issued once per completed request.
- R10: A chain walk visits at most MAX_CHAIN descriptors (default 8). A looping chain therefore ends there, with the capacity counted so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_table_base | input | AW | Descriptor table byte address, 4096-aligned |
| cfg_qsize_lg | input | LGW | Base-2 logarithm of the queue size |
| req_valid | input | 1 | Completion request, taken when busy is low |
| req_head | input | 16 | Head descriptor index reported in the used element |
| req_chain | input | 16 | First descriptor of the writable reply chain |
| req_len | input | 32 | Reply length in bytes |
| busy | output | 1 | A completion is in progress |
| rx_valid | input | 1 | Reply byte available |
| rx_byte | input | 8 | Reply byte |
| rx_ready | output | 1 | Engine takes the reply byte this cycle |
| mrd_en | output | 1 | Memory word read request |
| mrd_addr | output | AW | Byte address of the read word |
| mrd_data | input | 32 | Read word, valid the cycle after mrd_en |
| mwr_en | output | 1 | Memory byte write strobe |
| mwr_addr | output | AW | Byte write address |
| mwr_byte | output | 8 | Byte write data |
| irq_event | output | 1 | Completion event pulse |

## Verification
The hardest cases to reach from the ports are the chain-walk edge cases. These are a reply that fits a chain exactly or overruns it by a single byte, a writable chain that runs into a read-only tail, and a chain that loops back onto itself until the walk limit stops it. Directed cases build each of these descriptor layouts in the bench memory, including a used index of 0xFFFF to force the wrap. Random cases mix queue sizes, chain lengths, zero-length buffers, read-only tails, stream gaps and reply lengths slightly above or below the capacity. The bench compares the whole memory image against a model it computes itself.

// File: rtl/vq_used_pkg.sv
package vq_used_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_FLG, ST_W_FLG, ST_RD_LEN, ST_W_LEN, ST_RD_ADR, ST_W_ADR,
    ST_XFER, ST_ADV, ST_END, ST_RD_USED, ST_W_USED, ST_WR_OUT, ST_DONE
  } vqu_state_e;

  localparam int unsigned FLG_NEXT   = 0;
  localparam int unsigned FLG_WRITE  = 1;
  localparam int unsigned DESC_SHIFT = 4;
  localparam int unsigned OFS_LEN    = 8;
  localparam int unsigned OFS_FLG    = 12;
  localparam int unsigned PAGE_BYTES = 4096;
  localparam int unsigned ELEM_BYTES = 8;
  localparam int unsigned OUT_LAST   = 9;
endpackage

// File: rtl/vq_ring_geom.sv
module vq_ring_geom #(
  parameter int AW  = 32,
  parameter int IW  = 16,
  parameter int LGW = 4
) (
  input  logic [AW-1:0]  table_base,
  input  logic [LGW-1:0] qsize_lg,
  input  logic [IW-1:0]  used_idx,
  output logic [AW-1:0]  used_base,
  output logic [AW-1:0]  slot_addr
);
  localparam logic [AW-1:0] PG_MASK = AW'(vq_used_pkg::PAGE_BYTES - 1);

  logic [AW-1:0] qsz, ring_end, idx_m;

  always_comb begin
    qsz       = AW'(1) << qsize_lg;
    ring_end  = table_base + (qsz << 4) + AW'(4) + (qsz << 1);
    used_base = (ring_end + PG_MASK) & ~PG_MASK;
    idx_m     = AW'(used_idx) & (qsz - AW'(1));
    slot_addr = used_base + AW'(4) + (idx_m << 3);
  end
endmodule

// File: rtl/vq_seg_cursor.sv
module vq_seg_cursor #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_len,
  input  logic          ld_addr,
  input  logic          step,
  input  logic [LW-1:0] len_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic          rem_zero
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (ld_addr) addr_d = addr_in;
    else if (step) addr_d = addr_q + AW'(1);
    if (ld_len) rem_d = len_in;
    else if (step) rem_d = rem_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      if (ld_addr || step) addr_q <= addr_d;
      if (ld_len || step)  rem_q  <= rem_d;
    end
  end

  assign cur_addr = addr_q;
  assign rem_zero = (rem_q == '0);

  AST_SEG_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !rem_zero); // R3
endmodule

// File: rtl/vq_used_writer.sv
module vq_used_writer
  import vq_used_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LGW       = 4,
  parameter int MAX_CHAIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cfg_table_base,
  input  logic [LGW-1:0] cfg_qsize_lg,
  input  logic           req_valid,
  input  logic [15:0]    req_head,
  input  logic [15:0]    req_chain,
  input  logic [31:0]    req_len,
  output logic           busy,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  output logic           rx_ready,
  output logic           mrd_en,
  output logic [AW-1:0]  mrd_addr,
  input  logic [31:0]    mrd_data,
  output logic           mwr_en,
  output logic [AW-1:0]  mwr_addr,
  output logic [7:0]     mwr_byte,
  output logic           irq_event
);
  localparam int IW   = 16;
  localparam int LW   = 32;
  localparam int STW  = $clog2(MAX_CHAIN + 1);
  localparam int CAPW = LW + STW;

  vqu_state_e     st_q, st_d;
  logic [IW-1:0]  head_q, head_d, chain_q, chain_d, cur_q, cur_d, nxt_q, nxt_d, old_q, old_d;
  logic           hasnxt_q, hasnxt_d, pass_q, pass_d;
  logic [STW-1:0] steps_q, steps_d;
  logic [CAPW-1:0] cap_q, cap_d;
  logic [LW-1:0]  len_q, len_d, left_q, left_d;
  logic [3:0]     k_q, k_d;

  logic [AW-1:0]  desc_base, used_base, slot_addr, seg_addr;
  logic           rem_zero, xfer_go, fire;
  logic [31:0]    out_word;

  vq_ring_geom #(.AW(AW), .IW(IW), .LGW(LGW)) u_geom (
    .table_base(cfg_table_base), .qsize_lg(cfg_qsize_lg), .used_idx(old_q),
    .used_base(used_base), .slot_addr(slot_addr)
  );

  vq_seg_cursor #(.AW(AW), .LW(LW)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .ld_len(st_q == ST_W_LEN && pass_q), .ld_addr(st_q == ST_W_ADR), .step(fire),
    .len_in(mrd_data), .addr_in(AW'(mrd_data)),
    .cur_addr(seg_addr), .rem_zero(rem_zero)
  );

  assign desc_base = cfg_table_base + (AW'(cur_q) << DESC_SHIFT);
  assign xfer_go   = (st_q == ST_XFER) && (left_q != '0) && !rem_zero;
  assign fire      = xfer_go && rx_valid;
  assign rx_ready  = xfer_go;
  assign busy      = (st_q != ST_IDLE);
  assign irq_event = (st_q == ST_DONE);

  // memory read port
  always_comb begin
    mrd_en   = 1'b1;
    mrd_addr = '0;
    case (st_q)
      ST_RD_FLG:  mrd_addr = desc_base + AW'(OFS_FLG);
      ST_RD_LEN:  mrd_addr = desc_base + AW'(OFS_LEN);
      ST_RD_ADR:  mrd_addr = desc_base;
      ST_RD_USED: mrd_addr = used_base;
      default:    mrd_en   = 1'b0;
    endcase
  end

  // byte write port: reply data, then element, then index
  always_comb begin
    if (k_q < 4'd4)      out_word = {16'h0, head_q};
    else if (k_q < 4'd8) out_word = len_q;
    else                 out_word = {16'h0, old_q + 16'd1};
    mwr_en   = fire || (st_q == ST_WR_OUT);
    mwr_addr = seg_addr;
    mwr_byte = rx_byte;
    if (st_q == ST_WR_OUT) begin
      mwr_byte = out_word[8*k_q[1:0] +: 8];
      mwr_addr = (k_q < 4'(ELEM_BYTES)) ? slot_addr + AW'(k_q)
                                        : used_base + AW'(k_q - 4'd6);
    end
  end

  // next state
  always_comb begin
    st_d = st_q;  head_d = head_q;  chain_d = chain_q;  cur_d = cur_q;
    nxt_d = nxt_q;  old_d = old_q;  hasnxt_d = hasnxt_q;  pass_d = pass_q;
    steps_d = steps_q;  cap_d = cap_q;  len_d = len_q;  left_d = left_q;  k_d = k_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        head_d = req_head;  chain_d = req_chain;  cur_d = req_chain;  len_d = req_len;
        pass_d = 1'b0;  steps_d = '0;  cap_d = '0;  st_d = ST_RD_FLG;
      end
      ST_RD_FLG: st_d = ST_W_FLG;
      ST_W_FLG: begin
        if (!mrd_data[FLG_WRITE]) begin
          st_d = (steps_q == '0) ? ST_IDLE : ST_END;
        end else begin
          nxt_d = mrd_data[31:16];  hasnxt_d = mrd_data[FLG_NEXT];  st_d = ST_RD_LEN;
        end
      end
      ST_RD_LEN: st_d = ST_W_LEN;
      ST_W_LEN: begin
        if (pass_q) st_d = ST_RD_ADR;
        else begin
          cap_d = cap_q + CAPW'(mrd_data);  st_d = ST_ADV;
        end
      end
      ST_RD_ADR: st_d = ST_W_ADR;
      ST_W_ADR:  st_d = ST_XFER;
      ST_XFER: begin
        if (left_q == '0)  st_d = ST_RD_USED;
        else if (rem_zero) st_d = ST_ADV;
        else if (fire)     left_d = left_q - LW'(1);
      end
      ST_ADV: begin
        steps_d = steps_q + STW'(1);
        if (hasnxt_q && (steps_q + STW'(1)) < STW'(MAX_CHAIN)) begin
          cur_d = nxt_q;  st_d = ST_RD_FLG;
        end else st_d = ST_END;
      end
      ST_END: begin
        if (!pass_q && cap_q >= CAPW'(len_q)) begin
          pass_d = 1'b1;  cur_d = chain_q;  steps_d = '0;  left_d = len_q;  st_d = ST_RD_FLG;
        end else st_d = ST_IDLE;
      end
      ST_RD_USED: st_d = ST_W_USED;
      ST_W_USED: begin
        old_d = mrd_data[31:16];  k_d = '0;  st_d = ST_WR_OUT;
      end
      ST_WR_OUT: begin
        if (k_q == 4'(OUT_LAST)) st_d = ST_DONE;
        else k_d = k_q + 4'd1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  head_q <= '0;  chain_q <= '0;  cur_q <= '0;  nxt_q <= '0;
      old_q <= '0;  hasnxt_q <= 1'b0;  pass_q <= 1'b0;  steps_q <= '0;  cap_q <= '0;
      len_q <= '0;  left_q <= '0;  k_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        head_q <= head_d;  chain_q <= chain_d;  len_q <= len_d;
      end
      cur_q <= cur_d;  nxt_q <= nxt_d;  hasnxt_q <= hasnxt_d;  pass_q <= pass_d;
      steps_q <= steps_d;  cap_q <= cap_d;  left_q <= left_d;  k_q <= k_d;
      if (st_q == ST_W_USED) old_q <= old_d;
    end
  end

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> !irq_event); // R9
  AST_EVT_AFTER_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |-> $past(mwr_en)); // R5
  AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> left_q == $past(left_q) - LW'(1)); // R3
  AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_END && !pass_q && cap_q < CAPW'(len_q)) |=> !busy); // R8
  AST_BAD_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_W_FLG && !mrd_data[FLG_WRITE] && steps_q == '0) |=> !busy); // R7
  AST_WALK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    steps_q <= STW'(MAX_CHAIN)); // R10
endmodule

// File: tb/vq_used_writer_bench.sv
module vq_used_writer_bench;
  localparam int MAXC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [31:0] cfg_base;
  logic [3:0]  cfg_lg;
  logic req_valid;
  logic [15:0] req_head, req_chain;
  logic [31:0] req_len;
  logic busy, rx_valid, rx_ready, mrd_en, mwr_en, irq_event;
  logic [7:0]  rx_byte, mwr_byte;
  logic [31:0] mrd_addr, mrd_data, mwr_addr;

  always #4 clk = ~clk;

  vq_used_writer u_vq_used_writer (
    .clk(clk), .rst_n(rst_n), .cfg_table_base(cfg_base), .cfg_qsize_lg(cfg_lg),
    .req_valid(req_valid), .req_head(req_head), .req_chain(req_chain), .req_len(req_len),
    .busy(busy), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .mrd_en(mrd_en), .mrd_addr(mrd_addr), .mrd_data(mrd_data),
    .mwr_en(mwr_en), .mwr_addr(mwr_addr), .mwr_byte(mwr_byte), .irq_event(irq_event)
  );

  logic [7:0] mem [int unsigned];
  logic [7:0] exp_mem [int unsigned];
  logic [7:0] pay [0:1023];
  int unsigned rx_len, ptr, gap, evt_cnt, wr_cnt, last_wr;
  bit fire_pend;
  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic logic [7:0] rb(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [15:0] rd16(int unsigned a);
    return {rb(a + 1), rb(a)};
  endfunction
  function automatic logic [31:0] rd32(int unsigned a);
    return {rd16(a + 2), rd16(a)};
  endfunction
  task automatic w32(int unsigned a, logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
  endtask
  task automatic e32(int unsigned a, logic [31:0] v);
    for (int i = 0; i < 4; i++) exp_mem[a + i] = v[8*i +: 8];
  endtask
  function automatic int unsigned qsz();
    return 32'd1 << cfg_lg;
  endfunction
  function automatic int unsigned ubase();
    return ((cfg_base + 16 * qsz() + 4 + 2 * qsz() + 4095) / 4096) * 4096;
  endfunction
  task automatic put_desc(int unsigned idx, int unsigned addr, int unsigned len,
                          logic [15:0] flg, logic [15:0] nxt);
    int unsigned d = cfg_base + 16 * idx;
    w32(d, addr); w32(d + 4, 32'h0); w32(d + 8, len); w32(d + 12, {nxt, flg});
  endtask
  task automatic set_uidx(logic [15:0] v);
    mem[ubase() + 2] = v[7:0]; mem[ubase() + 3] = v[15:8];
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and reply stream, all at the falling edge
  always @(negedge clk) begin
    if (fire_pend) ptr++;
    rx_valid = (ptr < rx_len) && (($urandom % 100) >= gap);
    rx_byte  = pay[ptr % 1024];
    #1;
    fire_pend = rx_valid && rx_ready;
    if (mrd_en) mrd_data = rd32(mrd_addr);
    if (mwr_en) begin mem[mwr_addr] = mwr_byte; wr_cnt++; last_wr = mwr_addr; end
    if (irq_event) evt_cnt++;
  end

  task automatic model(int unsigned head, int unsigned chain, int unsigned len,
                       output bit ok, output int unsigned nwr);
    int unsigned sa[MAXC], sl[MAXC];
    int n = 0;
    longint cap = 0;
    int unsigned cur = chain, p = 0, u, slot;
    logic [15:0] fl, old;
    exp_mem = mem;
    nwr = 0;
    while (n < MAXC) begin
      fl = rd16(cfg_base + 16 * cur + 12);
      if (!fl[1]) break;
      sa[n] = rd32(cfg_base + 16 * cur);
      sl[n] = rd32(cfg_base + 16 * cur + 8);
      cap += sl[n];
      n++;
      if (!fl[0]) break;
      cur = rd16(cfg_base + 16 * cur + 14);
    end
    ok = (n > 0) && (cap >= len);
    if (ok) begin
      for (int s = 0; s < n; s++)
        for (int unsigned j = 0; j < sl[s] && p < len; j++) begin
          exp_mem[sa[s] + j] = pay[p]; p++; nwr++;
        end
      u = ubase();
      old = rd16(u + 2);
      slot = u + 4 + 8 * (old & (qsz() - 1));
      e32(slot, {16'h0, head[15:0]});
      e32(slot + 4, len);
      exp_mem[u + 2] = 8'(old + 16'd1);
      exp_mem[u + 3] = 8'((old + 16'd1) >> 8);
      nwr += 10;
    end
  endtask

  task automatic run(string req, int unsigned head, int unsigned chain, int unsigned len,
                     int unsigned gp, bit poke, output bit ok);
    int unsigned nwr, bad = 0, cyc = 0;
    for (int i = 0; i < 1024; i++) pay[i] = 8'($urandom);
    model(head, chain, len, ok, nwr);
    @(negedge clk);
    ptr = 0; fire_pend = 0; evt_cnt = 0; wr_cnt = 0; gap = gp; rx_len = len;
    req_valid = 1; req_head = 16'(head); req_chain = 16'(chain); req_len = len;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    while (busy && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        req_valid = 1; req_head = 16'(head ^ 1); req_chain = 16'(chain); req_len = 0;
      end else req_valid = 0;
    end
    req_valid = 0;
    chk(cyc < 4000, req, "completion timeout", cyc, 0);
    repeat (2) @(negedge clk);
    foreach (exp_mem[a]) if (rb(a) !== exp_mem[a]) bad++;
    foreach (mem[a]) if (!exp_mem.exists(a)) bad++;
    chk(bad == 0, req, "memory image mismatches", bad, 0);
    chk(wr_cnt == nwr, req, "byte writes", wr_cnt, nwr);
    chk(evt_cnt == (ok ? 1 : 0), {req, " R9"}, "events", evt_cnt, ok ? 1 : 0);
    chk(ptr == (ok ? len : 0), {req, " R7 R8"}, "reply bytes consumed", ptr, ok ? len : 0);
    rx_len = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int unsigned u, slot, s0;
    s0 = $urandom(32'd4242);
    rst_n = 0; req_valid = 0; req_head = 0; req_chain = 0; req_len = 0;
    cfg_base = 32'h0004_0000; cfg_lg = 3; rx_len = 0; ptr = 0; gap = 0; fire_pend = 0;
    mrd_data = 0; rx_valid = 0; rx_byte = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq_event && !mwr_en && !rx_ready, "R9", "reset idle", busy, 0);
    rst_n = 1;

    // R1 R4 R5: single buffer, exact fit
    mem.delete(); cfg_lg = 3;
    put_desc(2, 32'h0010_0000, 16, 16'h0002, 16'h0); set_uidx(16'h0005);
    run("R3", 16'h0102, 2, 16, 0, 0, ok);
    u = ubase(); slot = u + 4 + 8 * 5;
    chk(u == cfg_base + 4096, "R1", "used base", u, cfg_base + 4096);
    chk(rd32(slot) == 32'h0102, "R4", "element head", rd32(slot), 32'h0102);
    chk(rd32(slot + 4) == 16, "R4", "element length", rd32(slot + 4), 16);
    chk(rd16(u + 2) == 16'h0006, "R5", "used index", rd16(u + 2), 6);
    chk(last_wr == u + 3, "R5", "index written last", last_wr, u + 3);

    // R2 R3: three-buffer chain, last partly filled
    mem.delete();
    put_desc(1, 32'h0011_0000, 5, 16'h0003, 16'd4);
    put_desc(4, 32'h0012_0000, 7, 16'h0003, 16'd6);
    put_desc(6, 32'h0013_0000, 10, 16'h0002, 16'd0);
    set_uidx(16'h0);
    run("R2 R3", 7, 1, 15, 30, 0, ok);
    chk(ok, "R2", "chain fits", ok, 1);

    // R8: one byte over capacity
    mem.delete();
    put_desc(1, 32'h0011_0000, 5, 16'h0003, 16'd2);
    put_desc(2, 32'h0012_0000, 7, 16'h0002, 16'd0);
    run("R8", 3, 1, 13, 0, 0, ok);

    // R7: chain start read-only
    mem.delete();
    put_desc(0, 32'h0011_0000, 64, 16'h0001, 16'd1);
    put_desc(1, 32'h0012_0000, 64, 16'h0002, 16'd0);
    run("R7", 9, 0, 4, 0, 0, ok);

    // R6: read-only tail ends the chain, not counted
    mem.delete();
    put_desc(3, 32'h0011_0000, 10, 16'h0003, 16'd5);
    put_desc(5, 32'h0012_0000, 50, 16'h0001, 16'd0);
    run("R6", 1, 3, 10, 0, 0, ok);
    chk(ok, "R6", "fits writable part", ok, 1);
    run("R6", 1, 3, 11, 0, 0, ok);
    chk(!ok, "R6", "tail not counted", ok, 0);

    // R4 R5: index wrap 0xFFFF with small ring, R1 with size 1
    mem.delete(); cfg_lg = 2;
    put_desc(0, 32'h0011_0000, 8, 16'h0002, 16'd0); set_uidx(16'hFFFF);
    run("R4 R5", 16'hBEEF, 0, 8, 0, 0, ok);
    u = ubase();
    chk(rd16(u + 2) == 16'h0000, "R5", "index wrap", rd16(u + 2), 0);
    chk(rd32(u + 4 + 24) == 32'hBEEF, "R4", "masked slot", rd32(u + 28), 32'hBEEF);
    mem.delete(); cfg_lg = 0; cfg_base = 32'h0005_F000;
    put_desc(0, 32'h0011_0000, 3, 16'h0002, 16'd0); set_uidx(16'h0011);
    run("R1", 2, 0, 3, 0, 0, ok);

    // zero-length reply still completes
    mem.delete(); cfg_lg = 7; cfg_base = 32'h0004_0000;
    put_desc(9, 32'h0011_0000, 4, 16'h0002, 16'd0);
    run("R4", 5, 9, 0, 0, 0, ok);

    // R10: self loop limited to MAX_CHAIN descriptors
    mem.delete(); cfg_lg = 3;
    put_desc(2, 32'h0011_0000, 4, 16'h0003, 16'd2);
    run("R10", 4, 2, 40, 0, 0, ok);
    chk(!ok, "R10", "loop capacity limited", ok, 0);

    // R9: request while busy ignored
    mem.delete();
    put_desc(1, 32'h0011_0000, 20, 16'h0002, 16'd0);
    run("R9", 16'h0040, 1, 20, 10, 1, ok);

    // random chains
    for (int t = 0; t < 24; t++) begin
      int unsigned n, cap = 0, len, idx[4];
      mem.delete();
      cfg_lg = 4'($urandom_range(2, 6));
      n = $urandom_range(1, 4);
      for (int i = 0; i < 4; i++) idx[i] = (i * 3 + t) % qsz();
      for (int i = 0; i < n; i++) begin
        int unsigned sl = $urandom_range(0, 40);
        bit last = (i == n - 1);
        cap += sl;
        put_desc(idx[i], 32'h0020_0000 + i * 32'h1000, sl,
                 last ? 16'h0002 : 16'h0003, 16'(last ? 0 : idx[i + 1]));
      end
      if ($urandom_range(0, 3) == 0 && n < 4) begin
        put_desc(idx[n - 1], 32'h0020_0000 + (n - 1) * 32'h1000,
                 rd32(cfg_base + 16 * idx[n - 1] + 8), 16'h0003, 16'(idx[n]));
        put_desc(idx[n], 32'h0030_0000, 30, 16'h0000, 16'd0);
      end
      set_uidx(16'($urandom));
      len = $urandom_range(0, cap + 3);
      run("R3 R8", $urandom_range(0, 65535), idx[0], len, $urandom_range(0, 50), 0, ok);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule